// File: doc/BRIEF.md
# Pin Fault Compare and Capture

This block checks a device under test on every pin, once per clock. For each pin it compares the level sensed on the device's bus with the level the tester expects on that pin. A mismatch on a pin that is not disabled counts as a pin fault. Any pin fault, or a simulated fault forced by the host, raises a single master fault output in the same cycle.

The first pin fault opens a capture window of a fixed number of clock cycles. Pin faults seen during that window are ORed into a captured pattern. When the window ends, the pattern freezes and a valid flag goes high. While the flag is high, the monitor bus shows the frozen pattern. While it is low, the monitor bus carries the live expected-data bus. The host empties the pattern and rearms the capture with a synchronous clear.

Software disables pins through a serially loaded mask. Bits are shifted in MSB first, and a load strobe then moves the shifted word into the active mask. This lets a new mask be prepared without disturbing the one in use.

Top module: `pinfault_capture`

## Requirements
- R1: For every pin i, a pin fault exists when `dut_bus[i]` differs from `exp_bus[i]` and the pin is enabled. Any such fault drives `master_fault` high in the same cycle, with no register in the path.
- R2: A pin whose active mask bit is 1 is disabled. A mismatch on that pin neither raises `master_fault` nor enters the captured pattern.
- R3: While `mask_shift_en` is high, each clock shifts `mask_sdi` into bit 0 of a staging register, and the older bits move toward bit 27. After 28 shifts, the first bit shifted in sits in bit 27. The staging register does not affect the active mask until `mask_load` is high at a clock edge; that edge copies the staging register as it was before any shift in the same cycle.
- R4: `force_fault` high drives `master_fault` high in the same cycle. It never starts a capture.
- R5: When the block is idle and a pin fault is present at a clock edge, capture starts. The captured pattern becomes the OR of the pin faults present in that first cycle and in the following WINDOW_CYCLES-1 cycles (default 4 cycles in total).
- R6: `capt_valid` goes high in the cycle right after the last window cycle. Pin faults that appear after the window are not added to the pattern.
- R7: While `capt_valid` is high and no clear is applied, the captured pattern stays unchanged and `mon_bus` shows it, whatever `exp_bus` does.
- R8: While `capt_valid` is low, including during the capture window, `mon_bus` equals `exp_bus`.
- R9: When `host_clear` is high at a clock edge, the next cycle has `capt_valid` low and an empty pattern, and the capture is rearmed. Clear takes priority over any pin fault in the same cycle, so that fault is not captured.
- R10: After reset, the active mask and the staging register are all zeros (every pin enabled) and `capt_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dut_bus | input | NUM_PINS | Levels sensed from the device pins |
| exp_bus | input | NUM_PINS | Expected level for each pin |
| mask_sdi | input | 1 | Serial data for the disable mask |
| mask_shift_en | input | 1 | Shifts `mask_sdi` into the staging register |
| mask_load | input | 1 | Copies the staging register into the active mask |
| force_fault | input | 1 | Host-forced simulated fault |
| host_clear | input | 1 | Synchronous clear and rearm of the capture |
| master_fault | output | 1 | OR of all enabled pin faults and `force_fault` |
| capt_valid | output | 1 | Captured pattern is frozen; selects the monitor source |
| mon_bus | output | NUM_PINS | Frozen fault pattern or the live expected bus |

## Verification
The assertions assume a synchronous environment: `dut_bus`, `exp_bus`, `host_clear` and `force_fault` settle between edges, and reset is held for at least one edge before checking starts.

The window-length check counts the accumulate cycles after capture starts. It assumes that only `host_clear` or reset ends a capture early. To keep within these assumptions, the stimulus changes every input on the falling edge. It also applies each clear on its own, either between captures or together with a single new fault to test priority.

// File: rtl/pinfault_pkg.sv
package pinfault_pkg;

    // Phases of the capture sequencer
    typedef enum logic [1:0] {
        CAP_IDLE   = 2'd0,
        CAP_ACCUM  = 2'd1,
        CAP_FROZEN = 2'd2
    } cap_state_e;

    // Per-pin comparison result
    typedef struct packed {
        logic raw;     // sensed level differs from expected level
        logic masked;  // raw mismatch on an enabled pin
    } pin_cmp_t;

    // Width of a counter that indexes window cycles 0 .. cycles-1
    function automatic int win_cnt_width(input int cycles);
        return (cycles < 3) ? 1 : $clog2(cycles);
    endfunction

endpackage

// File: rtl/pinfault_compare.sv
module pinfault_compare
    import pinfault_pkg::*;
#(
    parameter int NUM_PINS = 28
) (
    input  logic [NUM_PINS-1:0] dut_bus,
    input  logic [NUM_PINS-1:0] exp_bus,
    input  logic [NUM_PINS-1:0] pin_disable,
    input  logic                force_fault,
    output logic [NUM_PINS-1:0] pin_fault,
    output logic                master_fault
);

    pin_cmp_t cmp [NUM_PINS];

    generate
        for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
            assign cmp[g] = '{raw:    dut_bus[g] ^ exp_bus[g],
                              masked: (dut_bus[g] ^ exp_bus[g]) & ~pin_disable[g]};
            assign pin_fault[g] = cmp[g].masked;
        end
    endgenerate

    assign master_fault = force_fault | (|pin_fault);

endmodule

// File: rtl/pinfault_mask_shift.sv
module pinfault_mask_shift #(
    parameter int NUM_PINS = 28
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                sdi,
    input  logic                shift_en,
    input  logic                load,
    output logic [NUM_PINS-1:0] active_mask
);

    logic [NUM_PINS-1:0] stage_q;
    logic [NUM_PINS-1:0] active_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q  <= '0;
            active_q <= '0;
        end else begin
            if (shift_en) begin
                stage_q <= {stage_q[NUM_PINS-2:0], sdi};
            end
            if (load) begin
                active_q <= stage_q;
            end
        end
    end

    assign active_mask = active_q;

endmodule

// File: rtl/pinfault_window.sv
module pinfault_window
    import pinfault_pkg::*;
#(
    parameter int NUM_PINS      = 28,
    parameter int WINDOW_CYCLES = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clear,
    input  logic [NUM_PINS-1:0] pin_fault,
    output logic [NUM_PINS-1:0] cap_pattern,
    output logic                capt_valid,
    output cap_state_e          state
);

    localparam int             CW       = win_cnt_width(WINDOW_CYCLES);
    localparam logic [CW-1:0]  LAST_IDX = CW'(WINDOW_CYCLES - 1);
    localparam logic [CW-1:0]  ONE_IDX  = CW'(1);

    cap_state_e          state_q, state_d;
    logic [CW-1:0]       idx_q, idx_d;
    logic [NUM_PINS-1:0] pat_q, pat_d;
    logic                fault_any;

    assign fault_any = |pin_fault;

    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        pat_d   = pat_q;
        if (clear) begin
            state_d = CAP_IDLE;
            idx_d   = '0;
            pat_d   = '0;
        end else begin
            case (state_q)
                CAP_IDLE: begin
                    if (fault_any) begin
                        pat_d   = pin_fault;
                        idx_d   = ONE_IDX;
                        state_d = (WINDOW_CYCLES <= 1) ? CAP_FROZEN : CAP_ACCUM;
                    end
                end
                CAP_ACCUM: begin
                    pat_d = pat_q | pin_fault;
                    if (idx_q == LAST_IDX) begin
                        state_d = CAP_FROZEN;
                        idx_d   = '0;
                    end else begin
                        idx_d = idx_q + ONE_IDX;
                    end
                end
                CAP_FROZEN: begin
                    state_d = CAP_FROZEN;
                end
                default: begin
                    state_d = CAP_IDLE;
                    idx_d   = '0;
                    pat_d   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CAP_IDLE;
            idx_q   <= '0;
            pat_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            pat_q   <= pat_d;
        end
    end

    assign cap_pattern = pat_q;
    assign capt_valid  = (state_q == CAP_FROZEN);
    assign state       = state_q;

endmodule

// File: rtl/pinfault_capture.sv
module pinfault_capture
    import pinfault_pkg::*;
#(
    parameter int NUM_PINS      = 28,
    parameter int WINDOW_CYCLES = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] dut_bus,
    input  logic [NUM_PINS-1:0] exp_bus,
    input  logic                mask_sdi,
    input  logic                mask_shift_en,
    input  logic                mask_load,
    input  logic                force_fault,
    input  logic                host_clear,
    output logic                master_fault,
    output logic                capt_valid,
    output logic [NUM_PINS-1:0] mon_bus
);

    logic [NUM_PINS-1:0] active_mask;
    logic [NUM_PINS-1:0] pin_fault;
    logic [NUM_PINS-1:0] cap_pattern;
    cap_state_e          win_state;

    pinfault_mask_shift #(
        .NUM_PINS(NUM_PINS)
    ) u_mask (
        .clk        (clk),
        .rst        (rst),
        .sdi        (mask_sdi),
        .shift_en   (mask_shift_en),
        .load       (mask_load),
        .active_mask(active_mask)
    );

    pinfault_compare #(
        .NUM_PINS(NUM_PINS)
    ) u_cmp (
        .dut_bus     (dut_bus),
        .exp_bus     (exp_bus),
        .pin_disable (active_mask),
        .force_fault (force_fault),
        .pin_fault   (pin_fault),
        .master_fault(master_fault)
    );

    pinfault_window #(
        .NUM_PINS     (NUM_PINS),
        .WINDOW_CYCLES(WINDOW_CYCLES)
    ) u_win (
        .clk        (clk),
        .rst        (rst),
        .clear      (host_clear),
        .pin_fault  (pin_fault),
        .cap_pattern(cap_pattern),
        .capt_valid (capt_valid),
        .state      (win_state)
    );

    // Monitor source: frozen pattern once valid, otherwise the live expected bus
    assign mon_bus = capt_valid ? cap_pattern : exp_bus;

endmodule

// File: rtl/pinfault_capture_chk.sv
module pinfault_capture_chk
    import pinfault_pkg::*;
#(
    parameter int NUM_PINS      = 28,
    parameter int WINDOW_CYCLES = 4
) (
    input logic                clk,
    input logic                rst,
    input logic                host_clear,
    input logic                force_fault,
    input logic                master_fault,
    input logic [NUM_PINS-1:0] pin_fault,
    input logic [NUM_PINS-1:0] cap_pattern,
    input logic                capt_valid,
    input cap_state_e          state,
    input logic [NUM_PINS-1:0] exp_bus,
    input logic [NUM_PINS-1:0] mon_bus
);

    // Counts the accumulate cycles of the current capture
    int accum_cnt;

    always_ff @(posedge clk) begin
        if (rst || host_clear) begin
            accum_cnt <= 0;
        end else if (state == CAP_ACCUM) begin
            accum_cnt <= accum_cnt + 1;
        end else if (state == CAP_IDLE) begin
            accum_cnt <= 0;
        end
    end

    p_force_master_r4: assert property (@(posedge clk) disable iff (rst)
        force_fault |-> master_fault);

    p_force_no_capture_r4: assert property (@(posedge clk) disable iff (rst)
        (state == CAP_IDLE && pin_fault == '0 && force_fault) |=> state == CAP_IDLE);

    p_first_capture_r5: assert property (@(posedge clk) disable iff (rst)
        (state == CAP_IDLE && (|pin_fault) && !host_clear)
        |=> (state != CAP_IDLE && cap_pattern == $past(pin_fault)));

    p_valid_nonempty_r5: assert property (@(posedge clk) disable iff (rst)
        capt_valid |-> cap_pattern != '0);

    p_window_len_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(capt_valid) |-> accum_cnt == WINDOW_CYCLES - 1);

    p_frozen_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (capt_valid && !host_clear) |=> (capt_valid && $stable(cap_pattern)));

    p_mon_live_r8: assert property (@(posedge clk) disable iff (rst)
        !capt_valid |-> mon_bus == exp_bus);

    p_clear_r9: assert property (@(posedge clk) disable iff (rst)
        host_clear |=> (!capt_valid && cap_pattern == '0));

endmodule

bind pinfault_capture pinfault_capture_chk #(
    .NUM_PINS     (NUM_PINS),
    .WINDOW_CYCLES(WINDOW_CYCLES)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .host_clear  (host_clear),
    .force_fault (force_fault),
    .master_fault(master_fault),
    .pin_fault   (pin_fault),
    .cap_pattern (cap_pattern),
    .capt_valid  (capt_valid),
    .state       (win_state),
    .exp_bus     (exp_bus),
    .mon_bus     (mon_bus)
);

// File: tb/test_pinfault_capture.sv
module test_pinfault_capture;

    localparam int NP = 28;

    typedef struct packed {
        logic [NP-1:0] err;
        logic          frc;
        logic          master;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{err: 28'h0000000, frc: 1'b0, master: 1'b0},
        '{err: 28'h0000001, frc: 1'b0, master: 1'b1},
        '{err: 28'h8000000, frc: 1'b0, master: 1'b1},
        '{err: 28'h0F0F0F0, frc: 1'b0, master: 1'b1},
        '{err: 28'h0000000, frc: 1'b1, master: 1'b1},
        '{err: 28'h0100000, frc: 1'b1, master: 1'b1}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NP-1:0] exp_bus = 28'hA5C31E7;
    logic [NP-1:0] err = '0;
    logic [NP-1:0] dut_bus;
    logic          mask_sdi = 1'b0;
    logic          mask_shift_en = 1'b0;
    logic          mask_load = 1'b0;
    logic          force_fault = 1'b0;
    logic          host_clear = 1'b0;
    logic          master_fault;
    logic          capt_valid;
    logic [NP-1:0] mon_bus;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    assign dut_bus = exp_bus ^ err;

    always #4 clk = ~clk;

    pinfault_capture i_pinfault_capture (
        .clk          (clk),
        .rst          (rst),
        .dut_bus      (dut_bus),
        .exp_bus      (exp_bus),
        .mask_sdi     (mask_sdi),
        .mask_shift_en(mask_shift_en),
        .mask_load    (mask_load),
        .force_fault  (force_fault),
        .host_clear   (host_clear),
        .master_fault (master_fault),
        .capt_valid   (capt_valid),
        .mon_bus      (mon_bus)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_clear();
        tick(); host_clear = 1'b1; err = '0; force_fault = 1'b0;
        tick(); host_clear = 1'b0;
    endtask

    task automatic shift_mask(input logic [NP-1:0] val);
        for (int i = NP - 1; i >= 0; i--) begin
            tick(); mask_sdi = val[i]; mask_shift_en = 1'b1;
        end
        tick(); mask_shift_en = 1'b0; mask_sdi = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0h expected %0h", 0, 1);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        #1;
        // R10 reset state
        check(capt_valid == 1'b0, "R10 valid low after reset", 32'(capt_valid), 0);
        check(mon_bus == exp_bus, "R10 mon live after reset", 32'(mon_bus), 32'(exp_bus));
        check(master_fault == 1'b0, "R10 no fault when equal", 32'(master_fault), 0);
        tick(); err = 28'h8000000; #1;
        check(master_fault == 1'b1, "R10 mask enabled after reset", 32'(master_fault), 1);
        do_clear();

        // R1 / R4 vector table
        for (int v = 0; v < NV; v++) begin
            tick(); err = VECS[v].err; force_fault = VECS[v].frc; #1;
            check(master_fault == VECS[v].master, "R1 master fault vector",
                  32'(master_fault), 32'(VECS[v].master));
        end
        do_clear();

        // R5 / R6 / R7 / R8 capture window
        tick(); err = 28'h1 << 0; #1;
        check(mon_bus == exp_bus, "R8 mon live at window start", 32'(mon_bus), 32'(exp_bus));
        tick();
        check(capt_valid == 1'b0, "R6 valid low in window", 32'(capt_valid), 0);
        err = 28'h1 << 3;
        tick();
        check(mon_bus == exp_bus, "R8 mon live in window", 32'(mon_bus), 32'(exp_bus));
        err = '0;
        tick();
        check(capt_valid == 1'b0, "R6 valid low in last window cycle", 32'(capt_valid), 0);
        err = 28'h1 << 5;
        tick();
        check(capt_valid == 1'b1, "R6 valid after window", 32'(capt_valid), 1);
        check(mon_bus == 28'h29, "R5 captured pattern", 32'(mon_bus), 32'h29);
        err = 28'h1 << 7;
        tick(); err = '0;
        check(mon_bus == 28'h29, "R6 late fault excluded", 32'(mon_bus), 32'h29);
        exp_bus = 28'h3C96D21;
        repeat (3) tick();
        check(capt_valid == 1'b1, "R7 stays frozen", 32'(capt_valid), 1);
        check(mon_bus == 28'h29, "R7 pattern held", 32'(mon_bus), 32'h29);

        // R9 clear priority
        tick(); host_clear = 1'b1; err = 28'h1 << 2;
        tick(); host_clear = 1'b0; err = 28'h1 << 4;
        check(capt_valid == 1'b0, "R9 cleared", 32'(capt_valid), 0);
        check(mon_bus == exp_bus, "R8 mon follows new exp", 32'(mon_bus), 32'(exp_bus));
        repeat (3) tick();
        err = '0;
        tick();
        check(mon_bus == 28'h10, "R9 clear beat same-cycle fault", 32'(mon_bus), 32'h10);
        do_clear();
        check(capt_valid == 1'b0, "R9 rearmed", 32'(capt_valid), 0);

        // R4 force does not capture
        tick(); force_fault = 1'b1; #1;
        check(master_fault == 1'b1, "R4 force raises master", 32'(master_fault), 1);
        repeat (5) tick();
        check(capt_valid == 1'b0, "R4 force no capture", 32'(capt_valid), 0);
        force_fault = 1'b0; #1;
        check(master_fault == 1'b0, "R4 master drops", 32'(master_fault), 0);

        // R3 / R2 mask staging and disable (pins 0 and 2 disabled)
        shift_mask(28'h0000005);
        err = 28'h1; #1;
        check(master_fault == 1'b1, "R3 shift alone inactive", 32'(master_fault), 1);
        do_clear();
        tick(); mask_load = 1'b1;
        tick(); mask_load = 1'b0; err = 28'h1; #1;
        check(master_fault == 1'b0, "R2 disabled pin ignored", 32'(master_fault), 0);
        repeat (5) tick();
        check(capt_valid == 1'b0, "R2 disabled pin not captured", 32'(capt_valid), 0);
        err = 28'h7; #1;
        check(master_fault == 1'b1, "R2 enabled pin faults", 32'(master_fault), 1);
        repeat (4) tick();
        err = '0;
        check(mon_bus == 28'h2, "R2 only enabled pin captured", 32'(mon_bus), 32'h2);
        do_clear();

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule